// File: doc/BRIEF.md
# Expansion ROM Window Decoder

This block keeps the configuration state a PCI target needs to expose a boot ROM: a 32-bit ROM base register, an 8-bit interrupt routing byte and a fixed interrupt pin code. It watches address phases on the bus and claims any memory access that lands inside a 64 KB window placed at the programmed base.

Configuration traffic arrives on a simplified port. It carries a dword offset, byte enables, write data and a write strobe. Read data for the selected offset comes back combinationally. The claim output is registered. It stays up until the bus reports that the access has ended. Only the hard reset clears state. The soft reset and stop inputs are accepted but change nothing.

Top module: `xrom_decoder`

## Requirements
- R1: At dword offset 0Ch, bits 31:16 hold the ROM base. Each of the two upper bytes is written only when its byte enable (bits 2 and 3) is set on a write.
- R2: At offset 0Ch, bits 15:1 always read as zero and ignore writes. Writing FFFF_F800h therefore reads back as FFFF_0000h, which advertises a 64 KB window.
- R3: Bit 0 at offset 0Ch is the ROM enable. It is read/write and is written only when byte enable 0 is set.
- R4: The claim output rises one clock after an address phase (bus_valid high) that hits. A hit requires both the ROM enable and the mem_en input to be high; if either is low, the phase is not claimed.
- R5: An address hits when bits 31:16 equal the base, so the range covers base through base+FFFCh. Addresses below or above that range, including a wrap past FFFF_FFFFh, are not claimed. Address bits 1:0 are ignored.
- R6: Only memory commands claim. The memory command codes are 6h, 7h, Ch, Eh and Fh; every other code on bus_cmd is refused.
- R7: Once set, the claim holds while no new phase starts. It clears one clock after bus_end is high in a cycle with no new address phase.
- R8: Hard reset (hrst_n low) clears the base, the ROM enable, the interrupt line byte and the claim.
- R9: The soft_rst and stop_req inputs leave every register and the decode result unchanged.
- R10: At dword offset 0Fh, byte 0 is the read/write interrupt line, written under byte enable 0. Its value has no effect on decoding.
- R11: At offset 0Fh, byte 1 reads 01h (the first interrupt pin) and bytes 2 and 3 read zero; writes to those bytes are ignored.
- R12: A read from any dword offset other than 0Ch and 0Fh returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hrst_n | input | 1 | Hard reset, active low, asynchronous |
| soft_rst | input | 1 | Soft reset request (no effect on this block) |
| stop_req | input | 1 | Stop request (no effect on this block) |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_off | input | 6 | Configuration dword offset |
| cfg_be | input | 4 | Configuration byte enables |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_off |
| mem_en | input | 1 | Memory-space enable from the command register |
| bus_valid | input | 1 | Address phase present this cycle |
| bus_addr | input | 32 | Address phase address |
| bus_cmd | input | 4 | Address phase command code |
| bus_end | input | 1 | Current access has ended |
| claim | output | 1 | Registered device-select claim |

## Verification
The hardest case to reach from the ports is the top edge of the window when the base is FFFFh. In that case the last dword, FFFF_FFFCh, must be claimed, and address 0000_0000h, which an adder-based range check would wrap onto, must not. The stimulus programs that base and probes both addresses, then places a base in the middle of the space and probes one step below it and one step above its top. To check the claim lifetime, the bench holds the bus idle for several cycles after a hit. It then raises bus_end and confirms the claim drops exactly one clock later.

// File: rtl/xrom_decoder.sv
module xrom_decoder #(
  parameter int              WIN_LOG2 = 16,
  parameter int              OFS_W    = 6,
  parameter logic [OFS_W-1:0] ROM_DW  = 6'h0C,
  parameter logic [OFS_W-1:0] INT_DW  = 6'h0F,
  parameter logic [7:0]      PIN_CODE = 8'h01
) (
  input  logic             clk,
  input  logic             hrst_n,
  input  logic             soft_rst,
  input  logic             stop_req,
  input  logic             cfg_wr,
  input  logic [OFS_W-1:0] cfg_off,
  input  logic [3:0]       cfg_be,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             mem_en,
  input  logic             bus_valid,
  input  logic [31:0]      bus_addr,
  input  logic [3:0]       bus_cmd,
  input  logic             bus_end,
  output logic             claim
);
  localparam int BASE_W = 32 - WIN_LOG2;

  logic [BASE_W-1:0] base_q;
  logic              rom_en_q;
  logic [7:0]        line_q;
  logic              claim_q;
  logic              hit;
  logic              wr_rom, wr_int;
  logic              unused_bits;

  function automatic logic is_mem(input logic [3:0] c);
    return (c == 4'h6) || (c == 4'h7) || (c == 4'hC) || (c == 4'hE) || (c == 4'hF);
  endfunction

  assign wr_rom = cfg_wr && (cfg_off == ROM_DW);
  assign wr_int = cfg_wr && (cfg_off == INT_DW);

  always_ff @(posedge clk or negedge hrst_n) begin
    if (!hrst_n) begin
      base_q   <= '0;
      rom_en_q <= 1'b0;
      line_q   <= '0;
    end else begin
      if (wr_rom) begin
        for (int i = WIN_LOG2; i < 32; i++)
          if (cfg_be[i/8]) base_q[i-WIN_LOG2] <= cfg_wdata[i];
        if (cfg_be[0]) rom_en_q <= cfg_wdata[0];
      end
      if (wr_int && cfg_be[0]) line_q <= cfg_wdata[7:0];
    end
  end

  assign hit = rom_en_q && mem_en && is_mem(bus_cmd) &&
               (bus_addr[31:WIN_LOG2] == base_q);

  always_ff @(posedge clk or negedge hrst_n) begin
    if (!hrst_n)        claim_q <= 1'b0;
    else if (bus_valid) claim_q <= hit;
    else if (bus_end)   claim_q <= 1'b0;
  end

  assign claim = claim_q;

  always_comb begin
    cfg_rdata = '0;
    if (cfg_off == ROM_DW)      cfg_rdata = {base_q, {(WIN_LOG2-1){1'b0}}, rom_en_q};
    else if (cfg_off == INT_DW) cfg_rdata = {16'h0000, PIN_CODE, line_q};
  end

  assign unused_bits = ^{bus_addr[WIN_LOG2-1:0], cfg_wdata[WIN_LOG2-1:1],
                         cfg_wdata[31:8], soft_rst, stop_req};

  assert_gate_mem_R4: assert property (@(posedge clk) disable iff (!hrst_n)
    (bus_valid && !mem_en) |=> !claim);

  assert_window_R5: assert property (@(posedge clk) disable iff (!hrst_n)
    (bus_valid && (bus_addr[31:WIN_LOG2] != base_q)) |=> !claim);

  assert_cmd_only_R6: assert property (@(posedge clk) disable iff (!hrst_n)
    (bus_valid && !is_mem(bus_cmd)) |=> !claim);

  assert_end_drop_R7: assert property (@(posedge clk) disable iff (!hrst_n)
    (bus_end && !bus_valid) |=> !claim);

  assert_hold_on_soft_R9: assert property (@(posedge clk) disable iff (!hrst_n)
    ((soft_rst || stop_req) && !cfg_wr) |=> ($stable(base_q) && $stable(rom_en_q) && $stable(line_q)));

  assert_size_zero_R2: assert property (@(posedge clk) disable iff (!hrst_n)
    (cfg_off == ROM_DW) |-> (cfg_rdata[WIN_LOG2-1:1] == '0));

  assert_pin_code_R11: assert property (@(posedge clk) disable iff (!hrst_n)
    (cfg_off == INT_DW) |-> (cfg_rdata[31:8] == {16'h0000, PIN_CODE}));
endmodule

// File: tb/xrom_decoder_bench.sv
module xrom_decoder_bench;
  logic        clk = 0;
  logic        hrst_n = 0;
  logic        soft_rst = 0, stop_req = 0;
  logic        cfg_wr = 0;
  logic [5:0]  cfg_off = 0;
  logic [3:0]  cfg_be = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic        mem_en = 0;
  logic        bus_valid = 0;
  logic [31:0] bus_addr = 0;
  logic [3:0]  bus_cmd = 0;
  logic        bus_end = 0;
  logic        claim;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  xrom_decoder u_xrom_decoder (
    .clk(clk), .hrst_n(hrst_n), .soft_rst(soft_rst), .stop_req(stop_req),
    .cfg_wr(cfg_wr), .cfg_off(cfg_off), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .mem_en(mem_en), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_cmd(bus_cmd), .bus_end(bus_end), .claim(claim));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cwr(input logic [5:0] off, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_off = off; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0; cfg_be = 0;
  endtask

  task automatic crd(input logic [5:0] off, output logic [31:0] d);
    cfg_off = off; #1; d = cfg_rdata;
  endtask

  task automatic phase(input logic [31:0] a, input logic [3:0] c, output logic cl);
    @(negedge clk);
    bus_valid = 1; bus_addr = a; bus_cmd = c;
    @(negedge clk);
    bus_valid = 0;
    cl = claim;
    bus_end = 1;
    @(negedge clk);
    bus_end = 0;
  endtask

  task automatic t_reset_state;
    logic [31:0] d;
    crd(6'h0C, d); chk("R8 base after reset", d, 32'h0);
    crd(6'h0F, d); chk("R8 line after reset", d, 32'h0000_0100);
    chk("R8 claim after reset", {31'b0, claim}, 32'h0);
  endtask

  task automatic t_rom_reg;
    logic [31:0] d;
    cwr(6'h0C, 4'b1000, 32'hAB00_0000);
    crd(6'h0C, d); chk("R1 upper byte only", d, 32'hAB00_0000);
    cwr(6'h0C, 4'b0100, 32'h00CD_0000);
    crd(6'h0C, d); chk("R1 byte 2 only", d, 32'hABCD_0000);
    cwr(6'h0C, 4'b0001, 32'h0000_0001);
    crd(6'h0C, d); chk("R3 enable set", d, 32'hABCD_0001);
    cwr(6'h0C, 4'b1110, 32'h1234_5670);
    crd(6'h0C, d); chk("R3 enable kept without be0", d, 32'h1234_0001);
  endtask

  task automatic t_size_probe;
    logic [31:0] d;
    cwr(6'h0C, 4'b1111, 32'hFFFF_F800);
    crd(6'h0C, d); chk("R2 size probe", d, 32'hFFFF_0000);
    cwr(6'h0C, 4'b1111, 32'h0000_FFFF);
    crd(6'h0C, d); chk("R2 reserved ignore", d, 32'h0000_0001);
  endtask

  task automatic t_line_pin;
    logic [31:0] d;
    cwr(6'h0F, 4'b1111, 32'hFFFF_FF5A);
    crd(6'h0F, d); chk("R10 R11 line and pin", d, 32'h0000_015A);
    cwr(6'h0F, 4'b1110, 32'h0000_0033);
    crd(6'h0F, d); chk("R10 line kept without be0", d, 32'h0000_015A);
  endtask

  task automatic t_unimpl;
    logic [31:0] d;
    crd(6'h00, d); chk("R12 offset 00", d, 32'h0);
    crd(6'h0D, d); chk("R12 offset 0D", d, 32'h0);
    crd(6'h3F, d); chk("R12 offset 3F", d, 32'h0);
  endtask

  task automatic t_enables;
    logic cl;
    cwr(6'h0C, 4'b1111, 32'h0012_0001);
    mem_en = 0;
    phase(32'h0012_0100, 4'h6, cl); chk("R4 mem_en low", {31'b0, cl}, 32'h0);
    mem_en = 1;
    phase(32'h0012_0100, 4'h6, cl); chk("R4 both enables", {31'b0, cl}, 32'h1);
    cwr(6'h0C, 4'b0001, 32'h0);
    phase(32'h0012_0100, 4'h6, cl); chk("R4 rom enable low", {31'b0, cl}, 32'h0);
    cwr(6'h0C, 4'b0001, 32'h1);
  endtask

  task automatic t_bounds;
    logic cl;
    phase(32'h0012_0000, 4'h6, cl); chk("R5 bottom", {31'b0, cl}, 32'h1);
    phase(32'h0012_FFFF, 4'h6, cl); chk("R5 top with low bits", {31'b0, cl}, 32'h1);
    phase(32'h0011_FFFC, 4'h6, cl); chk("R5 below", {31'b0, cl}, 32'h0);
    phase(32'h0013_0000, 4'h6, cl); chk("R5 above", {31'b0, cl}, 32'h0);
    cwr(6'h0C, 4'b1100, 32'hFFFF_0000);
    phase(32'hFFFF_FFFC, 4'h7, cl); chk("R5 top of space", {31'b0, cl}, 32'h1);
    phase(32'h0000_0000, 4'h7, cl); chk("R5 no wrap", {31'b0, cl}, 32'h0);
    cwr(6'h0C, 4'b1100, 32'h0012_0000);
  endtask

  task automatic t_cmds;
    logic cl;
    for (int c = 0; c < 16; c++) begin
      logic expc;
      expc = (c == 6) || (c == 7) || (c == 12) || (c == 14) || (c == 15);
      phase(32'h0012_0040, c[3:0], cl);
      chk($sformatf("R6 cmd %0h", c), {31'b0, cl}, {31'b0, expc});
    end
  endtask

  task automatic t_end;
    @(negedge clk);
    bus_valid = 1; bus_addr = 32'h0012_0200; bus_cmd = 4'hC;
    @(negedge clk);
    bus_valid = 0;
    chk("R4 claim one clock after phase", {31'b0, claim}, 32'h1);
    repeat (3) @(negedge clk);
    chk("R7 claim holds while idle", {31'b0, claim}, 32'h1);
    bus_end = 1;
    @(negedge clk);
    bus_end = 0;
    chk("R7 claim drops after end", {31'b0, claim}, 32'h0);
  endtask

  task automatic t_line_no_effect;
    logic cl;
    cwr(6'h0F, 4'b0001, 32'h0000_00FF);
    phase(32'h0012_0000, 4'h6, cl); chk("R10 line no effect hit", {31'b0, cl}, 32'h1);
    phase(32'h00FF_0000, 4'h6, cl); chk("R10 line no effect miss", {31'b0, cl}, 32'h0);
  endtask

  task automatic t_soft_stop;
    logic [31:0] d;
    logic cl;
    @(negedge clk); soft_rst = 1; stop_req = 1;
    repeat (3) @(negedge clk);
    crd(6'h0C, d); chk("R9 base kept", d, 32'h0012_0001);
    crd(6'h0F, d); chk("R9 line kept", d, 32'h0000_01FF);
    phase(32'h0012_0010, 4'h6, cl); chk("R9 decode kept", {31'b0, cl}, 32'h1);
    soft_rst = 0; stop_req = 0;
  endtask

  task automatic t_hard_reset;
    logic [31:0] d;
    @(negedge clk);
    bus_valid = 1; bus_addr = 32'h0012_0000; bus_cmd = 4'h6;
    @(negedge clk);
    bus_valid = 0;
    hrst_n = 0;
    #1;
    chk("R8 claim cleared", {31'b0, claim}, 32'h0);
    @(negedge clk); hrst_n = 1;
    crd(6'h0C, d); chk("R8 base cleared", d, 32'h0);
    crd(6'h0F, d); chk("R8 line cleared", d, 32'h0000_0100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    hrst_n = 1;
    @(negedge clk);
    t_reset_state;
    t_rom_reg;
    t_size_probe;
    t_line_pin;
    t_unimpl;
    t_enables;
    t_bounds;
    t_cmds;
    t_end;
    t_line_no_effect;
    t_soft_stop;
    t_hard_reset;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule